// File: doc/BRIEF.md
# Sub-vector element loop sequencer

This block walks a vector operation of `vl` elements in which each element is a group of 1 to 4 sub-elements of equal width. A `start` pulse captures a 2-bit group-length code, the element count, a 2-bit element-width code and a predicate mask holding one bit per group. The block then issues one sub-element per clock. Each issue slot carries the group (element) index, the position inside the group, the byte offset of that sub-element inside a packed register span, and an enable.

The predicate acts on whole groups. When a group's mask bit is clear, every sub-element of that group is still issued in its slot, but with the enable low. The loop therefore always takes `vl * len` issue cycles, whatever the mask holds. A one-cycle `done` pulse closes the loop.

The controller has three states. `ST_IDLE` waits for `start`. `ST_RUN` issues sub-elements. `ST_FIN` drives `done` for one cycle. The transitions are:
- `ST_IDLE -> ST_RUN` on `start` with a nonzero count.
- `ST_IDLE -> ST_FIN` on `start` with a count of zero.
- `ST_RUN -> ST_RUN` while slots remain.
- `ST_RUN -> ST_FIN` after the last sub-element of the last group.
- `ST_FIN -> ST_IDLE` unconditionally.

Top module: `subvec_loop_seq`

## Requirements
- R1: The group-length code maps 00 to 1, 01 to 2, 10 to 3 and 11 to 4 sub-elements. `sub_idx` runs from 0 to len-1 within each group.
- R2: Sub-elements are issued with `issue_valid` high on consecutive cycles, one per clock. `sub_idx` is the inner index and `elem_idx` the outer one, and the first slot appears in the cycle after the accepting clock edge. Slot k (counting from 0) has `elem_idx = k / len` and `sub_idx = k % len`.
- R3: `byte_ofs` equals (elem_idx * len + sub_idx) * bytes. The width code selects the bytes per sub-element: 00 = 1 byte (8 bits), 01 = 2 (16 bits), 10 = 4 (32 bits), 11 = 8 (64 bits).
- R4: `issue_en` equals bit `elem_idx` of the captured predicate for every sub-element of that group, and is low whenever `issue_valid` is low.
- R5: With code 00, each group yields exactly one slot with `sub_idx = 0`, and `vl` slots are issued in total.
- R6: With a count of zero, `done` is high in the cycle after the accepting edge and no slot is issued.
- R7: `done` is high for exactly one cycle, the cycle after the last slot, and never together with `issue_valid`.
- R8: The configuration inputs are captured only at the accepting edge. Changing them, or pulsing `start`, while a loop runs has no effect on that loop.
- R9: During and right after reset, `issue_valid`, `issue_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop when idle |
| len_code | input | 2 | Group length code, len = code + 1 |
| vl | input | $clog2(MAX_VL+1) | Number of groups |
| ew_code | input | 2 | Sub-element width code (8/16/32/64 bits) |
| pred | input | MAX_VL | Predicate, one bit per group |
| issue_valid | output | 1 | A sub-element slot is issued this cycle |
| issue_en | output | 1 | The slot is enabled by its group's predicate bit |
| elem_idx | output | $clog2(MAX_VL) | Group index of the slot |
| sub_idx | output | 2 | Position inside the group |
| byte_ofs | output | $clog2(4*MAX_VL)+3 | Byte offset in the packed span |
| done | output | 1 | One-cycle end-of-loop pulse |

## Verification
A wrong state register shows at once as a missing or extra `issue_valid` cycle, or as a `done` that is early, late or longer than one cycle. The bench checks every cycle from the accepting edge to one cycle past `done`. A corrupted nested counter makes `sub_idx`, `elem_idx` or `byte_ofs` deviate in the first slot after the fault, and a wrong group wrap already shows at the second group. A capture fault shows in the first slot, because the bench scrambles every configuration input right after `start`.

// File: rtl/subvec_pkg.sv
package subvec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/subvec_len_decode.sv
module subvec_len_decode (
    input  logic [1:0] code,
    output logic [2:0] len,
    output logic [1:0] last_sub
);
    // Length is code + 1, so the last sub-element index equals the code.
    always_comb begin
        len      = {1'b0, code} + 3'd1;
        last_sub = code;
    end
endmodule

// File: rtl/subvec_nest_counter.sv
module subvec_nest_counter #(
    parameter int ELEM_W = 3,
    parameter int LIN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [1:0]        last_sub,
    output logic [ELEM_W-1:0] elem,
    output logic [1:0]        sub,
    output logic [LIN_W-1:0]  lin,
    output logic              sub_wrap
);
    assign sub_wrap = (sub == last_sub);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            elem <= '0;
            sub  <= '0;
            lin  <= '0;
        end else if (step) begin
            lin <= lin + LIN_W'(1);
            if (sub_wrap) begin
                sub  <= '0;
                elem <= elem + ELEM_W'(1);
            end else begin
                sub <= sub + 2'd1;
            end
        end
    end
endmodule

// File: rtl/subvec_offset_gen.sv
module subvec_offset_gen #(
    parameter int LIN_W = 5,
    localparam int OFS_W = LIN_W + 3
) (
    input  logic [LIN_W-1:0] lin,
    input  logic [1:0]       ew_code,
    output logic [OFS_W-1:0] ofs
);
    always_comb begin
        ofs = {3'b000, lin} << ew_code;
    end
endmodule

// File: rtl/subvec_loop_seq.sv
module subvec_loop_seq #(
    parameter int MAX_VL = 8,
    localparam int VL_W   = $clog2(MAX_VL + 1),
    localparam int ELEM_W = $clog2(MAX_VL),
    localparam int LIN_W  = $clog2(MAX_VL * 4),
    localparam int OFS_W  = LIN_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        len_code,
    input  logic [VL_W-1:0]   vl,
    input  logic [1:0]        ew_code,
    input  logic [MAX_VL-1:0] pred,
    output logic              issue_valid,
    output logic              issue_en,
    output logic [ELEM_W-1:0] elem_idx,
    output logic [1:0]        sub_idx,
    output logic [OFS_W-1:0]  byte_ofs,
    output logic              done
);
    import subvec_pkg::*;

    seq_state_e        state_q, state_d;
    logic [1:0]        code_q;
    logic [VL_W-1:0]   vl_q;
    logic [1:0]        ew_q;
    logic [MAX_VL-1:0] pred_q;

    logic [2:0]        len_unused;
    logic [1:0]        last_sub;
    logic [ELEM_W-1:0] elem;
    logic [1:0]        sub;
    logic [LIN_W-1:0]  lin;
    logic              sub_wrap;
    logic              last_elem;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && start;

    subvec_len_decode u_len (
        .code     (code_q),
        .len      (len_unused),
        .last_sub (last_sub)
    );

    subvec_nest_counter #(.ELEM_W(ELEM_W), .LIN_W(LIN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q != ST_RUN),
        .step     (state_q == ST_RUN),
        .last_sub (last_sub),
        .elem     (elem),
        .sub      (sub),
        .lin      (lin),
        .sub_wrap (sub_wrap)
    );

    subvec_offset_gen #(.LIN_W(LIN_W)) u_ofs (
        .lin     (lin),
        .ew_code (ew_q),
        .ofs     (byte_ofs)
    );

    assign last_elem = (VL_W'(elem) == (vl_q - VL_W'(1)));

    // Configuration capture: only at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            vl_q   <= '0;
            ew_q   <= '0;
            pred_q <= '0;
        end else if (accept) begin
            code_q <= len_code;
            vl_q   <= vl;
            ew_q   <= ew_code;
            pred_q <= pred;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (vl == '0) ? ST_FIN : ST_RUN;
            ST_RUN:  if (sub_wrap && last_elem) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        issue_valid = (state_q == ST_RUN);
        issue_en    = issue_valid && pred_q[elem];
        done        = (state_q == ST_FIN);
        elem_idx    = elem;
        sub_idx     = sub;
    end
endmodule

// File: rtl/subvec_loop_seq_chk.sv
module subvec_loop_seq_chk #(
    parameter int MAX_VL = 8,
    localparam int VL_W   = $clog2(MAX_VL + 1),
    localparam int ELEM_W = $clog2(MAX_VL)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [VL_W-1:0]   vl,
    input logic [1:0]        state,
    input logic [1:0]        code_q,
    input logic              issue_valid,
    input logic              issue_en,
    input logic [ELEM_W-1:0] elem_idx,
    input logic [1:0]        sub_idx,
    input logic              done
);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && issue_valid));

    p_en_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> issue_valid);

    p_sub_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (sub_idx <= code_q));

    p_sub_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && sub_idx != code_q) |=>
            (issue_valid && sub_idx == 2'($past(sub_idx) + 2'd1) && $stable(elem_idx)));

    p_group_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && sub_idx != code_q) |=> $stable(issue_en));

    p_zero_vl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && start && vl == '0) |=> (done && !issue_valid));
endmodule

bind subvec_loop_seq subvec_loop_seq_chk #(.MAX_VL(MAX_VL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .vl          (vl),
    .state       (state_q),
    .code_q      (code_q),
    .issue_valid (issue_valid),
    .issue_en    (issue_en),
    .elem_idx    (elem_idx),
    .sub_idx     (sub_idx),
    .done        (done)
);

// File: tb/test_subvec_loop_seq.sv
module test_subvec_loop_seq;
    localparam int MAX_VL = 8;
    localparam int VL_W   = $clog2(MAX_VL + 1);
    localparam int ELEM_W = $clog2(MAX_VL);
    localparam int OFS_W  = $clog2(MAX_VL * 4) + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        len_code = '0;
    logic [VL_W-1:0]   vl = '0;
    logic [1:0]        ew_code = '0;
    logic [MAX_VL-1:0] pred = '0;
    logic              issue_valid, issue_en, done;
    logic [ELEM_W-1:0] elem_idx;
    logic [1:0]        sub_idx;
    logic [OFS_W-1:0]  byte_ofs;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    subvec_loop_seq #(.MAX_VL(MAX_VL)) i_subvec_loop_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .len_code(len_code),
        .vl(vl), .ew_code(ew_code), .pred(pred),
        .issue_valid(issue_valid), .issue_en(issue_en),
        .elem_idx(elem_idx), .sub_idx(sub_idx), .byte_ofs(byte_ofs),
        .done(done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_loop(input int code, input int n_vl, input int ew,
                            input logic [MAX_VL-1:0] pmask);
        int len = code + 1;
        int n = n_vl * len;
        @(negedge clk);
        start = 1'b1; len_code = 2'(code); vl = VL_W'(n_vl);
        ew_code = 2'(ew); pred = pmask;
        for (int k = 0; k <= n + 1; k++) begin
            @(negedge clk);
            // R8: scramble configuration, pulse start mid-loop
            start    = (k == 1) && (k < n);
            len_code = ~2'(code);
            vl       = VL_W'((n_vl + 3) % (MAX_VL + 1));
            ew_code  = ~2'(ew);
            pred     = ~pmask;
            if (k < n) begin
                chk("R2 valid", issue_valid, 1);
                chk("R2 elem_idx", elem_idx, k / len);
                if (code == 0) chk("R5 sub_idx", sub_idx, 0);
                else           chk("R1 sub_idx", sub_idx, k % len);
                chk("R3 byte_ofs", byte_ofs, longint'(k) << ew);
                chk("R4 enable", issue_en, pmask[k / len]);
                chk("R7 done low while issuing", done, 0);
            end else if (k == n) begin
                if (n == 0) chk("R6 done after zero count", done, 1);
                else        chk("R7 done after last slot", done, 1);
                chk("R7 no slot with done", issue_valid, 0);
            end else begin
                chk("R7 done single cycle", done, 0);
                chk("R8 idle after loop", issue_valid, 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R9 valid in reset", issue_valid, 0);
        chk("R9 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 valid after reset", issue_valid, 0);
        chk("R9 enable after reset", issue_en, 0);
        chk("R9 done after reset", done, 0);
        for (int c = 0; c < 4; c++)
            for (int v = 0; v <= MAX_VL; v++)
                for (int e = 0; e < 4; e++)
                    run_loop(c, v, e, MAX_VL'(8'hA5 ^ (c * 37 + v * 11 + e * 3)));
        // R4: uniform masks
        run_loop(3, MAX_VL, 2, '0);
        run_loop(2, MAX_VL, 1, '1);
        run_loop(1, 5, 3, MAX_VL'(8'h12));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule